// File: doc/BRIEF.md
# Block Grant Arbiter with Alternating Scan Direction

This block is the grant stage of one output node in a parallel matching scheduler, where a node stands for one delay of one output fiber. Each iteration it takes a request vector from the P input ports and an availability count k. In the same cycle it returns a grant vector that holds up to k of the asserted requests. The grants go to the first requests met when the ports are scanned from a round-robin pointer, either upward or downward around the ring.

The block keeps its own pointer and direction bit. A one-cycle slot-end pulse, raised after the last iteration of a time slot, flips the direction, so every iteration of a slot scans the same way and consecutive slots scan in opposite directions. The pointer moves forward by one port on every second slot-end pulse, whatever was requested or granted. Sibling arbiters serving different delays of the same fiber are given different starting pointers through parameters, so their grant blocks tend not to overlap. Arbiters for the same delay on different fibers get the same starting pointer.

Top module: `blk_grant_arb`

## Requirements
- R1: A grant bit is never high unless the request bit of the same port is high.
- R2: The number of grant bits equals the smaller of the number of requests and the availability count.
- R3: With the direction bit at 0, the scan visits ports in increasing index order, starting at the pointer and wrapping from port P-1 to port 0. The granted set is exactly the first k requested ports met in that order.
- R4: With the direction bit at 1, the scan visits ports in decreasing index order, starting at the pointer and wrapping from port 0 to port P-1. The granted set is exactly the first k requested ports met in that order.
- R5: An availability count of 0 yields an all-zero grant vector.
- R6: After reset the direction bit is 0 and the pointer equals (DELAY_IDX * floor(P / NUM_DELAYS)) mod P.
- R7: Each cycle with the slot-end input high inverts the direction bit. In cycles with slot-end low, both the direction bit and the pointer hold.
- R8: The pointer steps by one modulo P on the 2nd, 4th, 6th, ... slot-end pulse after reset, and stays put on the odd ones, whatever the requests and grants.
- R9: The grant vector depends on the current inputs and state with no register in between, so it is valid in the cycle its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slot_end | input | 1 | One-cycle pulse marking the end of a time slot |
| req | input | P | Request vector, one bit per input port |
| avail | input | AW | Availability count k, the most grants this node may issue |
| grant | output | P | Grant vector, one bit per input port |
| ptr_o | output | PW | Current round-robin pointer |
| dir_o | output | 1 | Current scan direction (0 = increasing index, 1 = decreasing index) |

## Verification
For every pointer position and both directions reached during the run, the grant vector is checked against all 256 request patterns of an 8-port configuration and every availability count from 0 to 9. This sweep covers four cases: an empty request vector, counts larger than the number of requests (which separate "grant all" from "grant k"), counts of zero, and request sets that lie on both sides of port 0 (which show whether the wrap goes the right way in each direction). Slot-end pulses are issued over more than one full turn of the pointer, which tells the every-second-pulse step apart from stepping every pulse or never. Idle stretches with no pulse show whether the state holds, and a second reset shows that the starting pointer comes back.

// File: rtl/blk_arb_pkg.sv
package blk_arb_pkg;

  // Modular add of two values already below m.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned m);
    int unsigned t;
    t = a + b;
    return (t >= m) ? (t - m) : t;
  endfunction

  // Modular subtract of two values already below m.
  function automatic int unsigned ring_sub(int unsigned a, int unsigned b, int unsigned m);
    return (a >= b) ? (a - b) : (a + m - b);
  endfunction

  // Scan direction encoding.
  typedef enum logic {
    SCAN_UP   = 1'b0,
    SCAN_DOWN = 1'b1
  } scan_dir_e;

endpackage

// File: rtl/blk_arb_state.sv
module blk_arb_state #(
  parameter int P        = 8,
  parameter int INIT_PTR = 0,
  localparam int PW      = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  output logic          core_rst_n,
  output logic [PW-1:0] ptr,
  output logic          dir
);

  localparam logic [PW-1:0] PTR_RST  = PW'(INIT_PTR);
  localparam logic [PW-1:0] PTR_LAST = PW'(P - 1);

  logic [1:0]    rst_sync;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          dir_q, dir_d;
  logic          par_q, par_d;
  logic          ptr_en;

  // Reset synchronizer: asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  // Next-state logic.
  assign ptr_en = slot_end & par_q;

  always_comb begin
    dir_d = dir_q;
    par_d = par_q;
    ptr_d = ptr_q;
    if (slot_end) begin
      dir_d = ~dir_q;
      par_d = ~par_q;
    end
    if (ptr_en) begin
      ptr_d = (ptr_q == PTR_LAST) ? '0 : (ptr_q + PW'(1));
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ptr_q <= PTR_RST;
      dir_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      if (slot_end) begin
        dir_q <= dir_d;
        par_q <= par_d;
      end
      if (ptr_en) begin
        ptr_q <= ptr_d;
      end
    end
  end

  assign ptr = ptr_q;
  assign dir = dir_q;

endmodule

// File: rtl/blk_arb_scan_map.sv
module blk_arb_scan_map
  import blk_arb_pkg::*;
#(
  parameter int P   = 8,
  localparam int PW = $clog2(P)
) (
  input  logic [P-1:0]  req,
  input  logic [PW-1:0] ptr,
  input  logic          dir,
  output logic [P-1:0]  scan_vec
);

  // scan_vec[s] is the request of the port visited at scan step s.
  for (genvar s = 0; s < P; s++) begin : g_step
    always_comb begin
      int unsigned port;
      if (scan_dir_e'(dir) == SCAN_DOWN)
        port = ring_sub(int'(ptr), s, P);
      else
        port = ring_add(int'(ptr), s, P);
      scan_vec[s] = (port < P) ? req[port] : 1'b0;
    end
  end

endmodule

// File: rtl/blk_arb_block_pick.sv
module blk_arb_block_pick #(
  parameter int P     = 8,
  parameter int AW    = $clog2(P + 1),
  localparam int CNTW = $clog2(P + 1),
  localparam int MW   = (CNTW > AW) ? CNTW : AW
) (
  input  logic [P-1:0]  scan_vec,
  input  logic [AW-1:0] avail,
  output logic [P-1:0]  pick_vec
);

  // Running count of requests seen before each scan step.
  logic [CNTW-1:0] seen [P+1];
  logic [MW-1:0]   limit;

  assign seen[0] = '0;
  assign limit   = MW'(avail);

  for (genvar s = 0; s < P; s++) begin : g_prefix
    assign seen[s+1]   = seen[s] + CNTW'(scan_vec[s]);
    assign pick_vec[s] = scan_vec[s] & (MW'(seen[s]) < limit);
  end

endmodule

// File: rtl/blk_arb_unmap.sv
module blk_arb_unmap
  import blk_arb_pkg::*;
#(
  parameter int P   = 8,
  localparam int PW = $clog2(P)
) (
  input  logic [P-1:0]  pick_vec,
  input  logic [PW-1:0] ptr,
  input  logic          dir,
  output logic [P-1:0]  grant
);

  // grant[p] takes the pick of the scan step that visits port p.
  for (genvar p = 0; p < P; p++) begin : g_port
    always_comb begin
      int unsigned step;
      if (scan_dir_e'(dir) == SCAN_DOWN)
        step = ring_sub(int'(ptr), p, P);
      else
        step = ring_sub(p, int'(ptr), P);
      grant[p] = (step < P) ? pick_vec[step] : 1'b0;
    end
  end

endmodule

// File: rtl/blk_grant_arb.sv
module blk_grant_arb #(
  parameter int P          = 8,
  parameter int NUM_DELAYS = 4,
  parameter int DELAY_IDX  = 0,
  parameter int AW         = $clog2(P + 1),
  localparam int PW        = $clog2(P),
  localparam int SPREAD    = P / NUM_DELAYS,
  localparam int INIT_PTR  = (DELAY_IDX * SPREAD) % P
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic [P-1:0]  req,
  input  logic [AW-1:0] avail,
  output logic [P-1:0]  grant,
  output logic [PW-1:0] ptr_o,
  output logic          dir_o
);

  logic          core_rst_n;
  logic [PW-1:0] ptr;
  logic          dir;
  logic [P-1:0]  scan_vec;
  logic [P-1:0]  pick_vec;

  blk_arb_state #(.P(P), .INIT_PTR(INIT_PTR)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_end   (slot_end),
    .core_rst_n (core_rst_n),
    .ptr        (ptr),
    .dir        (dir)
  );

  blk_arb_scan_map #(.P(P)) u_map (
    .req      (req),
    .ptr      (ptr),
    .dir      (dir),
    .scan_vec (scan_vec)
  );

  blk_arb_block_pick #(.P(P), .AW(AW)) u_pick (
    .scan_vec (scan_vec),
    .avail    (avail),
    .pick_vec (pick_vec)
  );

  blk_arb_unmap #(.P(P)) u_unmap (
    .pick_vec (pick_vec),
    .ptr      (ptr),
    .dir      (dir),
    .grant    (grant)
  );

  assign ptr_o = ptr;
  assign dir_o = dir;

endmodule

// File: rtl/blk_grant_arb_chk.sv
module blk_grant_arb_chk #(
  parameter int P   = 8,
  parameter int AW  = 4,
  localparam int PW = $clog2(P)
) (
  input logic          clk,
  input logic          core_rst_n,
  input logic          slot_end,
  input logic [P-1:0]  req,
  input logic [AW-1:0] avail,
  input logic [P-1:0]  grant,
  input logic [PW-1:0] ptr_o,
  input logic          dir_o
);

  // R1: grants only where requested
  p_grant_in_req_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (grant & ~req) == '0);

  // R2: grant count equals min(requests, availability)
  p_grant_count_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    $countones(grant) == (($countones(req) < int'(avail)) ? $countones(req) : int'(avail)));

  // R3/R4: the port under the pointer wins whenever it requests and k > 0
  p_ptr_first_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (req[ptr_o] && avail != '0) |-> grant[ptr_o]);

  // R5: zero availability gives no grants
  p_zero_avail_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (avail == '0) |-> (grant == '0));

  // R7: direction flips on every slot-end pulse
  p_dir_flip_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    slot_end |=> (dir_o != $past(dir_o)));

  // R7: state holds between pulses
  p_state_hold_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !slot_end |=> ($stable(dir_o) && $stable(ptr_o)));

  // R8: pointer moves by zero or one position modulo P on a pulse
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    slot_end |=> ((ptr_o == $past(ptr_o)) ||
                  (int'(ptr_o) == ((int'($past(ptr_o)) + 1) % P))));

  // R8: pointer always names a valid port
  p_ptr_range_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    int'(ptr_o) < P);

endmodule

bind blk_grant_arb blk_grant_arb_chk #(.P(P), .AW(AW)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .slot_end   (slot_end),
  .req        (req),
  .avail      (avail),
  .grant      (grant),
  .ptr_o      (ptr_o),
  .dir_o      (dir_o)
);

// File: tb/blk_grant_arb_bench.sv
module blk_grant_arb_bench;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 8;
  localparam int NDEL       = 4;
  localparam int DIDX       = 1;
  localparam int AW         = 4;
  localparam int PW         = 3;
  localparam int INIT       = (DIDX * (P / NDEL)) % P;

  logic          clk;
  logic          rst_n;
  logic          slot_end;
  logic [P-1:0]  req;
  logic [AW-1:0] avail;
  logic [P-1:0]  grant;
  logic [PW-1:0] ptr_o;
  logic          dir_o;

  int tests;
  int fails;
  int m_ptr;
  int m_dir;
  int m_par;

  blk_grant_arb #(.P(P), .NUM_DELAYS(NDEL), .DELAY_IDX(DIDX), .AW(AW)) u_blk_grant_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_end (slot_end),
    .req      (req),
    .avail    (avail),
    .grant    (grant),
    .ptr_o    (ptr_o),
    .dir_o    (dir_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Software scan: walk the ring from ptr, grant the first k requests.
  function automatic logic [P-1:0] scan_model(logic [P-1:0] r, int k, int pt, int dr);
    logic [P-1:0] g;
    int cnt;
    g = '0;
    cnt = 0;
    for (int s = 0; s < P; s++) begin
      int port;
      port = dr ? ((pt - s + P) % P) : ((pt + s) % P);
      if (r[port] && cnt < k) begin
        g[port] = 1'b1;
        cnt++;
      end
    end
    return g;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    slot_end = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_ptr = INIT;
    m_dir = 0;
    m_par = 0;
  endtask

  task automatic pulse_slot();
    @(negedge clk);
    slot_end = 1'b1;
    @(negedge clk);
    slot_end = 1'b0;
    if (m_par == 1) m_ptr = (m_ptr + 1) % P;
    m_par = 1 - m_par;
    m_dir = 1 - m_dir;
    #1;
    check(int'(dir_o) == m_dir, "R7", "direction after pulse", int'(dir_o), m_dir);
    check(int'(ptr_o) == m_ptr, "R8", "pointer after pulse", int'(ptr_o), m_ptr);
  endtask

  task automatic sweep();
    @(negedge clk);
    for (int r = 0; r < 256; r++) begin
      for (int k = 0; k <= 9; k++) begin
        logic [P-1:0] exp_g;
        int nreq;
        int nexp;
        req = r[P-1:0];
        avail = k[AW-1:0];
        #1;
        exp_g = scan_model(r[P-1:0], k, m_ptr, m_dir);
        nreq = $countones(r[P-1:0]);
        nexp = (nreq < k) ? nreq : k;
        check((grant & ~req) == '0, "R1", "grant without request", int'(grant), int'(req));
        check($countones(grant) == nexp, "R2", "grant count", $countones(grant), nexp);
        if (k == 0)
          check(grant == exp_g, "R5", "zero availability grants", int'(grant), int'(exp_g));
        else if (m_dir == 0)
          check(grant == exp_g, "R3", "upward scan grants", int'(grant), int'(exp_g));
        else
          check(grant == exp_g, "R4", "downward scan grants", int'(grant), int'(exp_g));
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    tests = 0;
    fails = 0;
    rst_n = 1'b0;
    slot_end = 1'b0;
    req = '0;
    avail = '0;
    do_reset();

    // R6: reset state
    #1;
    check(int'(ptr_o) == INIT, "R6", "pointer after reset", int'(ptr_o), INIT);
    check(dir_o == 1'b0, "R6", "direction after reset", int'(dir_o), 0);

    // R9: grant valid 1 time unit after inputs change, no clock edge in between
    @(negedge clk);
    req = 8'b0010_0110;
    avail = 4'd2;
    #1;
    check(grant == scan_model(8'b0010_0110, 2, m_ptr, m_dir), "R9", "same-cycle grant",
          int'(grant), int'(scan_model(8'b0010_0110, 2, m_ptr, m_dir)));

    // R7: idle cycles keep state
    repeat (5) @(negedge clk);
    #1;
    check(int'(ptr_o) == m_ptr, "R7", "pointer held while idle", int'(ptr_o), m_ptr);
    check(int'(dir_o) == m_dir, "R7", "direction held while idle", int'(dir_o), m_dir);

    // Sweep across more than one full turn of the pointer in both directions.
    sweep();
    for (int slot = 0; slot < 18; slot++) begin
      pulse_slot();
      sweep();
    end

    // R6: reset mid-run restores the starting state
    do_reset();
    #1;
    check(int'(ptr_o) == INIT, "R6", "pointer after second reset", int'(ptr_o), INIT);
    check(dir_o == 1'b0, "R6", "direction after second reset", int'(dir_o), 0);
    pulse_slot();
    sweep();

    finish_run();
  end

endmodule